// File: doc/BRIEF.md
# Cascaded Event Pending Controller

This block gathers up to 96 single-cycle event pulses into three 32-bit pending words. Events arrive on a set strobe carrying a 7-bit index and are retired by a clear strobe with the same encoding or by write-one-to-clear accesses on a small register bus. The two top bits of word 0 are hardware-owned summary flags. They show whether word 1 or word 2 holds anything, so a handler can read word 0 first and look further only when a flag is up.

Three interrupt outputs are formed from the pending words. Each output has its own set of three enable masks, one mask per pending word. Each output is a level signal: it stays high while any enabled pending bit remains and drops when the last enabled bit is cleared.

Top module: `evt_cascade_ctrl`

## Requirements
- R1: An event index selects the pending word with bits [6:5] and the bit within that word with bits [4:0]. Indices 0–31 go to word 0, 32–63 to word 1 and 64–95 to word 2. Indices 96–127 are ignored by both strobes.
- R2: Setting any event in word 1 also sets bit 30 of word 0. Setting any event in word 2 also sets bit 31 of word 0.
- R3: A clear strobe that leaves word 1 at zero clears bit 30 of word 0 on the same edge, and one that leaves word 2 at zero clears bit 31. While the word still holds a bit, its summary flag stays set.
- R4: A bus write to offset 0x0 clears every bit of word 0 in [29:0] that is written as 1. Bits 30 and 31 are unaffected.
- R5: Set and clear strobes with index 30 or 31 are ignored.
- R6: Bus writes to offset 0x4 (word 1) have no effect.
- R7: A bus write to offset 0x8 clears every bit of word 2 written as 1. If word 2 is then zero, bit 31 of word 0 clears on the same edge.
- R8: irq[k] is high whenever, for some word w, pending word w ANDed with mask (k,w) is non-zero. It follows the registers and falls as soon as the last enabled bit is cleared.
- R9: When a set and a clear of the same bit (by strobe or by bus) happen in one cycle, the bit ends up set, together with its summary flag.
- R10: Mask (k,w) is read/write at byte offset 0x0C + 0x0C·k + 4·w. Offsets 0x30–0x3C read as zero.
- R11: After reset, every pending word, every mask, irq and bus_rdata are zero.
- R12: A bus read loads bus_rdata on its clock edge with the register value from before that edge's updates. bus_rdata holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Event set strobe |
| set_idx | input | 7 | Index of event to set |
| clr_vld | input | 1 | Event clear strobe |
| clr_idx | input | 7 | Index of event to clear |
| bus_vld | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Level interrupt outputs |

## Verification
The bench targets the summary flags. It clears the second-to-last bit of a word and then the last one: a design that drops the flag too early, or that never drops it, reads back a wrong word 0. It also writes all ones to word 0 and word 1, where a design that lets software touch the flags or the read-only word loses bits. Same-cycle set and clear collisions, including one on the last bit of word 2, catch a design where the clear wins or where the flag is lost. A random phase compares irq and read data on every cycle against a behavioural model, so a stale or latched interrupt, or read data taken after the update, shows up.

// File: rtl/evt_cascade_ctrl.sv
module evt_cascade_ctrl #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_vld,
  input  logic [6:0]    set_idx,
  input  logic          clr_vld,
  input  logic [6:0]    clr_idx,
  input  logic          bus_vld,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [2:0]    irq
);
  localparam int NW   = 3;
  localparam int NIRQ = 3;
  localparam int NM   = NW * NIRQ;
  localparam int BW   = $clog2(DW);
  localparam int CB1  = DW - 2;
  localparam int CB2  = DW - 1;
  localparam int SW   = AW - 2;

  logic [DW-1:0] pend [NW];
  logic [DW-1:0] nxt  [NW];
  logic [DW-1:0] mask [NM];
  logic [DW-1:0] rd_val;

  logic [1:0]    set_w, clr_w;
  logic [BW-1:0] set_b, clr_b;
  logic          set_ok, clr_ok, bus_wen, bus_rd;
  logic [SW-1:0] sel;

  assign set_w   = set_idx[BW+1:BW];
  assign set_b   = set_idx[BW-1:0];
  assign clr_w   = clr_idx[BW+1:BW];
  assign clr_b   = clr_idx[BW-1:0];
  assign set_ok  = set_vld && (int'(set_w) < NW) && !(set_w == 2'd0 && int'(set_b) >= CB1);
  assign clr_ok  = clr_vld && (int'(clr_w) < NW) && !(clr_w == 2'd0 && int'(clr_b) >= CB1);
  assign sel     = bus_addr[AW-1:2];
  assign bus_wen = bus_vld && bus_wr;
  assign bus_rd  = bus_vld && !bus_wr;

  always_comb begin
    for (int w = 0; w < NW; w++) nxt[w] = pend[w];
    for (int w = 0; w < NW; w++)
      if (clr_ok && int'(clr_w) == w) nxt[w][clr_b] = 1'b0;
    if (bus_wen && int'(sel) == 0) nxt[0] = nxt[0] & ~{2'b00, bus_wdata[DW-3:0]};
    if (bus_wen && int'(sel) == 2) nxt[2] = nxt[2] & ~bus_wdata;
    if (clr_ok && clr_w == 2'd1 && nxt[1] == '0) nxt[0][CB1] = 1'b0;
    if (((clr_ok && clr_w == 2'd2) || (bus_wen && int'(sel) == 2)) && nxt[2] == '0)
      nxt[0][CB2] = 1'b0;
    for (int w = 0; w < NW; w++)
      if (set_ok && int'(set_w) == w) nxt[w][set_b] = 1'b1;
    if (set_ok && set_w == 2'd1) nxt[0][CB1] = 1'b1;
    if (set_ok && set_w == 2'd2) nxt[0][CB2] = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NW; i++)
      if (int'(sel) == i) rd_val = pend[i];
    for (int j = 0; j < NM; j++)
      if (int'(sel) == NW + j) rd_val = mask[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) pend[w] <= '0;
      for (int j = 0; j < NM; j++) mask[j] <= '0;
      bus_rdata <= '0;
    end else begin
      for (int w = 0; w < NW; w++) pend[w] <= nxt[w];
      for (int j = 0; j < NM; j++)
        if (bus_wen && int'(sel) == NW + j) mask[j] <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  always_comb begin
    for (int k = 0; k < NIRQ; k++) begin
      irq[k] = 1'b0;
      for (int w = 0; w < NW; w++)
        irq[k] = irq[k] | (|(pend[w] & mask[k*NW+w]));
    end
  end

  p_casc1_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0][CB1] == (|pend[1]));
  p_casc2_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0][CB2] == (|pend[2]));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok && set_w == 2'd0 |=> pend[0][$past(set_b)]);
  p_word1_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && int'(sel) == 1 && !set_vld && !clr_vld |=> $stable(pend[1]));
  p_flags_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && int'(sel) == 0 && !set_vld && !clr_vld |=> $stable(pend[0][CB2:CB1]));
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/evt_cascade_ctrl_test.sv
module evt_cascade_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic set_vld = 0, clr_vld = 0, bus_vld = 0, bus_wr = 0;
  logic [6:0] set_idx = 0, clr_idx = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0] irq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [31:0] m_p [3];
  logic [31:0] m_m [9];
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  evt_cascade_ctrl uut (.clk, .rst_n, .set_vld, .set_idx, .clr_vld, .clr_idx,
    .bus_vld, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [5:0] a);
    int s = int'(a[5:2]);
    if (s < 3) return m_p[s];
    if (s < 12) return m_m[s-3];
    return 32'h0;
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] r = 3'b000;
    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 3; w++)
        if ((m_p[w] & m_m[k*3+w]) != 0) r[k] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_p[i] = 0;
      for (int i = 0; i < 9; i++) m_m[i] = 0;
      m_rd = 0;
    end else begin
      logic [31:0] np [3];
      int sw, sb, cw, cb, s;
      bit sok, cok;
      for (int i = 0; i < 3; i++) np[i] = m_p[i];
      s  = int'(bus_addr[5:2]);
      sw = set_idx / 32; sb = set_idx % 32;
      cw = clr_idx / 32; cb = clr_idx % 32;
      sok = set_vld && sw < 3 && !(sw == 0 && sb >= 30);
      cok = clr_vld && cw < 3 && !(cw == 0 && cb >= 30);
      if (bus_vld && !bus_wr) m_rd = m_read(bus_addr);
      if (cok) np[cw][cb] = 1'b0;
      if (bus_vld && bus_wr && s == 0) np[0] = np[0] & ~(bus_wdata & 32'h3FFF_FFFF);
      if (bus_vld && bus_wr && s == 2) np[2] = np[2] & ~bus_wdata;
      if (cok && cw == 1 && np[1] == 0) np[0][30] = 1'b0;
      if (((cok && cw == 2) || (bus_vld && bus_wr && s == 2)) && np[2] == 0) np[0][31] = 1'b0;
      if (sok) begin
        np[sw][sb] = 1'b1;
        if (sw == 1) np[0][30] = 1'b1;
        if (sw == 2) np[0][31] = 1'b1;
      end
      if (bus_vld && bus_wr && s >= 3 && s < 12) m_m[s-3] = bus_wdata;
      for (int i = 0; i < 3; i++) m_p[i] = np[i];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq == m_irq(), "R8 irq vs model", {29'd0, irq}, {29'd0, m_irq()});
      chk(bus_rdata == m_rd, "R12 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic drive(bit sv, int si, bit cv, int ci, bit bv, bit bw, int ba, logic [31:0] bd);
    set_vld = sv; set_idx = 7'(si); clr_vld = cv; clr_idx = 7'(ci);
    bus_vld = bv; bus_wr = bw; bus_addr = 6'(ba); bus_wdata = bd;
    @(negedge clk);
    set_vld = 0; clr_vld = 0; bus_vld = 0; bus_wr = 0;
  endtask

  task automatic ev_set(int i);  drive(1, i, 0, 0, 0, 0, 0, 0); endtask
  task automatic ev_clr(int i);  drive(0, 0, 1, i, 0, 0, 0, 0); endtask
  task automatic wr(int a, logic [31:0] d); drive(0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    drive(0, 0, 0, 0, 1, 0, a, 0);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 3'b000, "R11 irq after reset", {29'd0, irq}, 0);
    chk(bus_rdata == 0, "R11 rdata after reset", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    rd_chk(6'h00, 32'h0, "R11 word0 reset");
    rd_chk(6'h2C, 32'h0, "R11 mask reset");
    ev_set(30); ev_set(31);
    rd_chk(6'h00, 32'h0, "R5 set of index 30/31 ignored");
    ev_set(5);
    rd_chk(6'h00, 32'h0000_0020, "R1 word0 bit5");
    ev_set(33);
    rd_chk(6'h04, 32'h0000_0002, "R1 word1 bit1");
    rd_chk(6'h00, 32'h4000_0020, "R2 flag30 set");
    ev_set(70);
    rd_chk(6'h00, 32'hC000_0020, "R2 flag31 set");
    ev_set(100); ev_clr(127);
    rd_chk(6'h08, 32'h0000_0040, "R1 index 100 ignored");
    ev_clr(30); ev_clr(31);
    rd_chk(6'h00, 32'hC000_0020, "R5 clear of index 30/31 ignored");
    wr(6'h00, 32'hFFFF_FFFF);
    rd_chk(6'h00, 32'hC000_0000, "R4 w1c keeps flags");
    wr(6'h04, 32'hFFFF_FFFF);
    rd_chk(6'h04, 32'h0000_0002, "R6 word1 read-only");
    ev_set(40); ev_clr(33);
    rd_chk(6'h00, 32'hC000_0000, "R3 flag30 held while word1 busy");
    ev_clr(40);
    rd_chk(6'h00, 32'h8000_0000, "R3 flag30 cleared when word1 empty");
    ev_set(65);
    wr(6'h08, 32'h0000_0002);
    rd_chk(6'h00, 32'h8000_0000, "R7 flag31 held while word2 busy");
    wr(6'h08, 32'h0000_0040);
    rd_chk(6'h00, 32'h0000_0000, "R7 flag31 cleared on empty word2");
    drive(1, 7, 1, 7, 0, 0, 0, 0);
    drive(1, 8, 0, 0, 1, 1, 0, 32'h0000_0100);
    ev_set(66);
    drive(1, 66, 1, 66, 0, 0, 0, 0);
    rd_chk(6'h00, 32'h8000_0180, "R9 set beats clears");
    rd_chk(6'h08, 32'h0000_0004, "R9 word2 bit kept");
    wr(6'h0C, 32'h0000_0080);
    chk(irq == 3'b001, "R8 irq0 from mask0 word0", {29'd0, irq}, 1);
    wr(6'h20, 32'h0000_0004);
    chk(irq == 3'b011, "R10 irq1 from mask at 0x20", {29'd0, irq}, 3);
    wr(6'h24, 32'h8000_0000);
    chk(irq == 3'b111, "R10 irq2 from mask at 0x24", {29'd0, irq}, 7);
    rd_chk(6'h20, 32'h0000_0004, "R10 mask readback");
    rd_chk(6'h30, 32'h0, "R10 unmapped reads zero");
    ev_clr(66);
    chk(irq == 3'b001, "R8 irqs fall on clear", {29'd0, irq}, 1);
    wr(6'h00, 32'h0000_0080);
    chk(irq == 3'b000, "R8 irq0 falls on bus clear", {29'd0, irq}, 0);
    drive(1, 9, 0, 0, 1, 0, 0, 0);
    chk(bus_rdata == 32'h0000_0100, "R12 read shows pre-edge value", bus_rdata, 32'h100);
    @(negedge clk);
    chk(bus_rdata == 32'h0000_0100, "R12 rdata holds", bus_rdata, 32'h100);
    rd_chk(6'h00, 32'h0000_0300, "R12 fresh read");
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 3));
      drive($urandom_range(0, 1) == 1, int'($urandom_range(0, 127)),
            $urandom_range(0, 1) == 1, int'($urandom_range(0, 127)),
            op != 0, op == 1, int'($urandom_range(0, 15)) * 4,
            ($urandom_range(0, 1) == 1) ? 32'($urandom) : (32'h1 << $urandom_range(0, 31)));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule